// File: doc/BRIEF.md
# Memory Type Range Resolver

This unit answers one question for a physical address range: which caching memory type applies to it. Three programmed sources supply the answer. The first is a bank of 88 fixed type bytes that covers the lowest megabyte. The second is a set of variable ranges, each defined by a base and a mask. The third is a default type that applies wherever nothing else matches. A requester pulses `req` with a start address and an exclusive end address. Some cycles later the unit raises `done` for one cycle. At that point it presents the resolved type, a flag that says whether one source covers the whole range on its own, and a validity bit.

A range can cross the edge of a variable range. When it does, the unit cuts the range into pieces. It resolves each piece and merges the piece types under a precedence rule, and it stops early as soon as the merged result becomes uncacheable. The same registered write port programs every register. A separate top-of-upper-memory limit forces write-back above 4 GiB.

The controller is a four-state machine:
- IDLE waits for a request. From IDLE, a disabled or unloaded table jumps straight to FINISH. A start address that hits the fixed bank also jumps straight to FINISH. Every other request goes to SCAN.
- SCAN tests one variable range per cycle. After the last range, or after an uncacheable merge, it moves to PIECE.
- PIECE merges the piece type into the running result. It then either returns to SCAN for the next piece or moves to FINISH.
- FINISH raises `done` and returns to IDLE.

Top module: `mtr_resolver`

## Requirements
- R1: When the default register has never been written since reset, or its global enable (bit 11) is clear, a request completes with `res_type` = 8'hFF, `res_valid` = 0 and `res_uniform` = 0.
- R2: When the start address is below 0x100000 and the fixed enable (default register bit 10) is set, the fixed bank supplies the type and `res_uniform` is 0. With the fixed enable clear, the same address is resolved through the variable ranges and the default.
- R3: Fixed bank entry selection depends on the start address. Below 0x80000 the entry is start>>16. From 0x80000 to 0xBFFFF it is 8 plus the 16 KB step above 0x80000. From 0xC0000 up it is 24 plus the 4 KB step above 0xC0000. Entries are written with kind 0, entry number in `wr_idx` and type in data bits 7:0.
- R4: A variable range takes part only when bit 11 of its mask word (kind 2) is set. An address hits the range when address AND mask equals base AND mask, using only bits 12 and up of base and mask. The range's type is held in bits 7:0 of its base word (kind 1).
- R5: Types are encoded UC=0, WC=1, WT=4, WB=6. When two hitting types meet, the merge works as follows. UC with anything gives UC. WB with WT gives WT. Two equal types keep that type. Any other differing pair gives UC.
- R6: With no hitting range the default type (default register bits 7:0, kind 3) is returned. `res_uniform` is 1 only when a single range, or the default alone, covers the whole request.
- R7: A request crosses a range when its start and its last byte hit that range differently, or when it strictly encloses the range base. The request is then split at the range end (if start hit) or at the base, each piece is resolved in turn, and the piece types are merged under R5. The result is UC as soon as the merge gives UC. `res_uniform` is 0 for a split request.
- R8: When the upper-memory limit (kind 4) is nonzero, the last piece starts at or above 4 GiB and the exclusive end is below the limit, the result is WB.
- R9: `done` lasts one cycle. `res_type`, `res_uniform` and `res_valid` change only as `done` rises and stay held afterwards. A request arriving while `busy` is high, including in the `done` cycle, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 3 | Register kind: 0 fixed entry, 1 range base, 2 range mask, 3 default, 4 upper-memory limit |
| wr_idx | input | 7 | Fixed entry number or range number |
| wr_data | input | ADDR_W | Write data |
| req | input | 1 | Lookup request strobe |
| req_start | input | ADDR_W | First byte of the range |
| req_end | input | ADDR_W | Byte after the last one (exclusive) |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle completion strobe |
| res_type | output | 8 | Resolved memory type |
| res_uniform | output | 1 | One source covers the whole range |
| res_valid | output | 1 | Result is a real type |

## Verification
Two events can fall in the same cycle: a new request and the completion of the previous lookup. The bench starts a three-piece split request. It issues a second request two cycles later, while the scan is running. It issues a third in the exact cycle `done` is observed high. The run must show exactly one completion, carrying the first request's type. That result must then stay unchanged while the unit remains idle.

// File: rtl/mtr_pkg.sv
package mtr_pkg;

    typedef enum logic [2:0] {
        WK_FIXED   = 3'd0,
        WK_VBASE   = 3'd1,
        WK_VMASK   = 3'd2,
        WK_DEFAULT = 3'd3,
        WK_TOM2    = 3'd4
    } wr_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_PIECE  = 2'd2,
        ST_FINISH = 2'd3
    } rs_state_e;

    localparam logic [7:0] MT_UC   = 8'h00;
    localparam logic [7:0] MT_WC   = 8'h01;
    localparam logic [7:0] MT_WT   = 8'h04;
    localparam logic [7:0] MT_WB   = 8'h06;
    localparam logic [7:0] MT_NONE = 8'hFF;

    localparam int FIX_ENTRIES  = 88;
    localparam int PAGE_BITS    = 12;
    localparam int ON_BIT       = 11;
    localparam int DEF_FIX_BIT  = 10;
    localparam int DEF_GLOB_BIT = 11;

    typedef struct packed {
        logic [7:0] ty;
        logic       stop;
    } merge_t;

    // precedence merge of two hitting types
    function automatic merge_t mt_merge(input logic [7:0] a, input logic [7:0] b);
        merge_t r;
        if (a == MT_UC || b == MT_UC) begin
            r.ty = MT_UC; r.stop = 1'b1;
        end else if ((a == MT_WB && b == MT_WT) || (a == MT_WT && b == MT_WB)) begin
            r.ty = MT_WT; r.stop = 1'b0;
        end else if (a != b) begin
            r.ty = MT_UC; r.stop = 1'b1;
        end else begin
            r.ty = a; r.stop = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/mtr_regs.sv
module mtr_regs
    import mtr_pkg::*;
#(
    parameter int ADDR_W  = 36,
    parameter int NUM_VAR = 8,
    localparam int PGW    = ADDR_W - PAGE_BITS
)(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [2:0]                    wr_kind,
    input  logic [6:0]                    wr_idx,
    input  logic [ADDR_W-1:0]             wr_data,
    output logic [FIX_ENTRIES*8-1:0]      fix_bank,
    output logic [NUM_VAR-1:0][PGW-1:0]   var_page,
    output logic [NUM_VAR-1:0][7:0]       var_ty,
    output logic [NUM_VAR-1:0][PGW-1:0]   var_mpage,
    output logic [NUM_VAR-1:0]            var_on,
    output logic [7:0]                    def_type,
    output logic                          fix_en,
    output logic                          glob_en,
    output logic                          loaded,
    output logic [ADDR_W-1:0]             tom2
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fix_bank <= '0;
        end else if (wr_en && wr_kind == WK_FIXED) begin
            for (int e = 0; e < FIX_ENTRIES; e++) begin
                if (wr_idx == 7'(e)) fix_bank[e*8 +: 8] <= wr_data[7:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            var_page  <= '0;
            var_ty    <= '0;
            var_mpage <= '0;
            var_on    <= '0;
        end else if (wr_en) begin
            for (int v = 0; v < NUM_VAR; v++) begin
                if (wr_idx == 7'(v)) begin
                    if (wr_kind == WK_VBASE) begin
                        var_page[v] <= wr_data[ADDR_W-1:PAGE_BITS];
                        var_ty[v]   <= wr_data[7:0];
                    end
                    if (wr_kind == WK_VMASK) begin
                        var_mpage[v] <= wr_data[ADDR_W-1:PAGE_BITS];
                        var_on[v]    <= wr_data[ON_BIT];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            def_type <= MT_UC;
            fix_en   <= 1'b0;
            glob_en  <= 1'b0;
            loaded   <= 1'b0;
            tom2     <= '0;
        end else if (wr_en) begin
            if (wr_kind == WK_DEFAULT) begin
                def_type <= wr_data[7:0];
                fix_en   <= wr_data[DEF_FIX_BIT];
                glob_en  <= wr_data[DEF_GLOB_BIT];
                loaded   <= 1'b1;
            end
            if (wr_kind == WK_TOM2) tom2 <= wr_data;
        end
    end

endmodule

// File: rtl/mtr_fixsel.sv
module mtr_fixsel
    import mtr_pkg::*;
(
    input  logic [19:0]               addr,
    input  logic [FIX_ENTRIES*8-1:0]  bank,
    output logic [7:0]                ty
);

    logic [6:0] idx;

    always_comb begin
        if (!addr[19])      idx = {4'b0, addr[18:16]};            // 64 KB steps
        else if (!addr[18]) idx = 7'd8 + {3'b0, addr[17:14]};     // 16 KB steps
        else                idx = 7'd24 + {1'b0, addr[17:12]};    // 4 KB steps
        ty = bank[32'(idx) * 8 +: 8];
    end

endmodule

// File: rtl/mtr_varprobe.sv
module mtr_varprobe
    import mtr_pkg::*;
#(
    parameter int ADDR_W = 36,
    localparam int PGW   = ADDR_W - PAGE_BITS
)(
    input  logic [PGW-1:0]    base_page,
    input  logic [PGW-1:0]    mask_page,
    input  logic              on,
    input  logic [ADDR_W-1:0] start,
    input  logic [ADDR_W-1:0] end_incl,
    output logic              hit,
    output logic              split,
    output logic [ADDR_W:0]   pend
);

    localparam logic [ADDR_W:0] TOP  = {1'b1, {ADDR_W{1'b0}}};
    localparam logic [ADDR_W:0] PAGE = (ADDR_W+1)'(1) << PAGE_BITS;

    logic [ADDR_W-1:0] base_a, mask_a;
    logic [ADDR_W:0]   size, raw;
    logic              end_hit, encl;

    always_comb begin
        base_a  = {base_page, {PAGE_BITS{1'b0}}};
        mask_a  = {mask_page, {PAGE_BITS{1'b0}}};
        size    = TOP - {1'b0, mask_a};
        hit     = on && (((start ^ base_a) & mask_a) == '0);
        end_hit = on && (((end_incl ^ base_a) & mask_a) == '0);
        encl    = (start < base_a) && (end_incl > base_a);
        split   = on && ((hit != end_hit) || encl);
        raw     = hit ? ({1'b0, base_a} + size) : {1'b0, base_a};
        // degenerate cut: advance one page so the walk always moves forward
        pend    = (raw <= {1'b0, start}) ? ({1'b0, start} + PAGE) : raw;
    end

endmodule

// File: rtl/mtr_resolver.sv
module mtr_resolver
    import mtr_pkg::*;
#(
    parameter int ADDR_W     = 36,
    parameter int NUM_VAR    = 8,
    parameter bit HAVE_FIXED = 1'b1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_kind,
    input  logic [6:0]        wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_start,
    input  logic [ADDR_W-1:0] req_end,
    output logic              busy,
    output logic              done,
    output logic [7:0]        res_type,
    output logic              res_uniform,
    output logic              res_valid
);

    localparam int IDX_W = (NUM_VAR > 1) ? $clog2(NUM_VAR) : 1;
    localparam int PGW   = ADDR_W - PAGE_BITS;
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(NUM_VAR - 1);
    localparam logic [ADDR_W-1:0] FIX_LIMIT = ADDR_W'(32'h0010_0000);

    // programmed state
    logic [FIX_ENTRIES*8-1:0]     fix_bank;
    logic [NUM_VAR-1:0][PGW-1:0]  var_page, var_mpage;
    logic [NUM_VAR-1:0][7:0]      var_ty;
    logic [NUM_VAR-1:0]           var_on;
    logic [7:0]                   def_type;
    logic                         fix_en, glob_en, loaded;
    logic [ADDR_W-1:0]            tom2;

    mtr_regs #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_idx(wr_idx), .wr_data(wr_data), .fix_bank(fix_bank),
        .var_page(var_page), .var_ty(var_ty), .var_mpage(var_mpage),
        .var_on(var_on), .def_type(def_type), .fix_en(fix_en),
        .glob_en(glob_en), .loaded(loaded), .tom2(tom2)
    );

    // fixed bank lookup, present only when the part has one
    logic [7:0] fix_ty;
    logic       fix_path;
    generate
        if (HAVE_FIXED) begin : g_fixed
            mtr_fixsel i_fixsel (.addr(req_start[19:0]), .bank(fix_bank), .ty(fix_ty));
            assign fix_path = fix_en && (req_start < FIX_LIMIT);
        end else begin : g_nofixed
            logic [FIX_ENTRIES*8+19:0] unused_fix;
            assign unused_fix = {fix_bank, req_start[19:0]};
            assign fix_ty   = MT_NONE;
            assign fix_path = 1'b0 & fix_en & (^unused_fix);
        end
    endgenerate

    // walk state
    rs_state_e          st, st_n;
    logic [ADDR_W-1:0]  cur_start, cur_start_n;
    logic [ADDR_W-1:0]  cur_end, cur_end_n;
    logic [ADDR_W-1:0]  orig_excl, orig_excl_n;
    logic [ADDR_W:0]    pend_r, pend_n;
    logic               rep, rep_n;
    logic [7:0]         prev, prev_n;
    logic               piece_uni, piece_uni_n;
    logic [7:0]         acc, acc_n;
    logic               first, first_n;
    logic [IDX_W-1:0]   scan_idx, scan_idx_n;
    logic [7:0]         r_type_n;
    logic               r_uni_n, r_valid_n;

    // one range probe, shared across the scan
    logic              p_hit, p_split;
    logic [ADDR_W:0]   p_pend, p_pend_m1;

    mtr_varprobe #(.ADDR_W(ADDR_W)) i_probe (
        .base_page(var_page[scan_idx]), .mask_page(var_mpage[scan_idx]),
        .on(var_on[scan_idx]), .start(cur_start), .end_incl(cur_end),
        .hit(p_hit), .split(p_split), .pend(p_pend)
    );

    merge_t     m_scan, m_piece;
    logic [7:0] piece_ty, tmp_ty;
    logic       tmp_uni, tmp_stop, scan_stop, tom2_hit, more;

    always_comb begin
        p_pend_m1 = p_pend - 1'b1;
        m_scan    = mt_merge(prev, var_ty[scan_idx]);
        scan_stop = p_hit && (prev != MT_NONE) && m_scan.stop;
        piece_ty  = (prev != MT_NONE) ? prev : def_type;
        m_piece   = mt_merge(acc, piece_ty);
        tmp_ty    = first ? piece_ty : m_piece.ty;
        tmp_uni   = first ? piece_uni : 1'b0;
        tmp_stop  = !first && m_piece.stop;
        more      = rep && (pend_r < {1'b0, orig_excl});
        tom2_hit  = (tom2 != '0) && (cur_start[ADDR_W-1:32] != '0) && (orig_excl < tom2);
    end

    // next-state and datapath
    always_comb begin
        st_n        = st;
        cur_start_n = cur_start;
        cur_end_n   = cur_end;
        orig_excl_n = orig_excl;
        pend_n      = pend_r;
        rep_n       = rep;
        prev_n      = prev;
        piece_uni_n = piece_uni;
        acc_n       = acc;
        first_n     = first;
        scan_idx_n  = scan_idx;
        r_type_n    = res_type;
        r_uni_n     = res_uniform;
        r_valid_n   = res_valid;
        unique case (st)
            ST_IDLE: begin
                if (req) begin
                    cur_start_n = req_start;
                    cur_end_n   = req_end - 1'b1;
                    orig_excl_n = req_end;
                    if (!loaded || !glob_en) begin
                        r_type_n = MT_NONE; r_uni_n = 1'b0; r_valid_n = 1'b0;
                        st_n = ST_FINISH;
                    end else if (fix_path) begin
                        r_type_n = fix_ty; r_uni_n = 1'b0; r_valid_n = 1'b1;
                        st_n = ST_FINISH;
                    end else begin
                        scan_idx_n  = '0;
                        prev_n      = MT_NONE;
                        rep_n       = 1'b0;
                        piece_uni_n = 1'b1;
                        first_n     = 1'b1;
                        st_n        = ST_SCAN;
                    end
                end
            end
            ST_SCAN: begin
                if (p_split) begin
                    cur_end_n   = p_pend_m1[ADDR_W-1:0];
                    pend_n      = p_pend;
                    rep_n       = 1'b1;
                    piece_uni_n = 1'b0;
                end
                if (p_hit) begin
                    if (prev == MT_NONE) begin
                        prev_n = var_ty[scan_idx];
                    end else begin
                        prev_n      = m_scan.ty;
                        piece_uni_n = 1'b0;
                    end
                end
                if (scan_stop || scan_idx == LAST_IDX) st_n = ST_PIECE;
                else scan_idx_n = scan_idx + 1'b1;
            end
            ST_PIECE: begin
                acc_n = tmp_ty;
                if (tmp_stop) begin
                    r_type_n = tmp_ty; r_uni_n = 1'b0; r_valid_n = 1'b1;
                    st_n = ST_FINISH;
                end else if (more) begin
                    cur_start_n = pend_r[ADDR_W-1:0];
                    cur_end_n   = orig_excl - 1'b1;
                    scan_idx_n  = '0;
                    prev_n      = MT_NONE;
                    rep_n       = 1'b0;
                    piece_uni_n = 1'b1;
                    first_n     = 1'b0;
                    st_n        = ST_SCAN;
                end else begin
                    r_type_n  = tom2_hit ? MT_WB : tmp_ty;
                    r_uni_n   = tmp_uni;
                    r_valid_n = 1'b1;
                    st_n      = ST_FINISH;
                end
            end
            ST_FINISH: st_n = ST_IDLE;
            default:   st_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_start   <= '0;
            cur_end     <= '0;
            orig_excl   <= '0;
            pend_r      <= '0;
            rep         <= 1'b0;
            prev        <= MT_NONE;
            piece_uni   <= 1'b1;
            acc         <= MT_UC;
            first       <= 1'b1;
            scan_idx    <= '0;
            res_type    <= MT_NONE;
            res_uniform <= 1'b0;
            res_valid   <= 1'b0;
        end else begin
            cur_start   <= cur_start_n;
            cur_end     <= cur_end_n;
            orig_excl   <= orig_excl_n;
            pend_r      <= pend_n;
            rep         <= rep_n;
            prev        <= prev_n;
            piece_uni   <= piece_uni_n;
            acc         <= acc_n;
            first       <= first_n;
            scan_idx    <= scan_idx_n;
            res_type    <= r_type_n;
            res_uniform <= r_uni_n;
            res_valid   <= r_valid_n;
        end
    end

    // outputs
    always_comb begin
        busy = (st != ST_IDLE);
        done = (st == ST_FINISH);
    end

endmodule

// File: rtl/mtr_resolver_chk.sv
module mtr_resolver_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req,
    input logic       busy,
    input logic       done,
    input logic [7:0] res_type,
    input logic       res_uniform,
    input logic       res_valid
);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> (done || ($stable(res_type) && $stable(res_uniform) && $stable(res_valid)))); // R9

    AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> busy); // R9

    AST_INVALID_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !res_valid) |-> (res_type == 8'hFF && !res_uniform)); // R1

    AST_UNIFORM_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_uniform) |-> res_valid); // R6

endmodule

bind mtr_resolver mtr_resolver_chk i_chk (.*);

// File: tb/test_mtr_resolver.sv
module test_mtr_resolver;

    localparam int CLK_P  = 10;
    localparam int ADDR_W = 36;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [2:0]        wr_kind = '0;
    logic [6:0]        wr_idx = '0;
    logic [ADDR_W-1:0] wr_data = '0;
    logic              req = 1'b0;
    logic [ADDR_W-1:0] req_start = '0;
    logic [ADDR_W-1:0] req_end = '0;
    logic              busy, done, res_uniform, res_valid;
    logic [7:0]        res_type;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    mtr_resolver i_mtr_resolver (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_idx(wr_idx), .wr_data(wr_data), .req(req), .req_start(req_start),
        .req_end(req_end), .busy(busy), .done(done), .res_type(res_type),
        .res_uniform(res_uniform), .res_valid(res_valid)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] k, input int idx, input logic [ADDR_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = k; wr_idx = 7'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // range of 2**lg bytes at base, type ty, enabled when on
    task automatic set_var(input int i, input logic [ADDR_W-1:0] base, input int lg,
                           input logic [7:0] ty, input bit on);
        logic [ADDR_W-1:0] m;
        m = ~((ADDR_W'(1) << lg) - 1'b1);
        m[11] = on;
        wreg(3'd1, i, base | ADDR_W'(ty));
        wreg(3'd2, i, m);
    endtask

    task automatic lookup(input logic [ADDR_W-1:0] s, input logic [ADDR_W-1:0] e,
                          input logic [7:0] ety, input logic euni, input logic eval,
                          input string tag);
        int n;
        @(negedge clk);
        req = 1'b1; req_start = s; req_end = e;
        @(negedge clk);
        req = 1'b0;
        n = 0;
        while (!done && n < 300) begin
            @(negedge clk);
            n++;
        end
        if (!done) begin
            chk({tag, " timeout"}, 64'd0, 64'd1);
        end else begin
            chk({tag, " type"}, 64'(res_type), 64'(ety));
            chk({tag, " uniform"}, 64'(res_uniform), 64'(euni));
            chk({tag, " valid"}, 64'(res_valid), 64'(eval));
        end
    endtask

    task automatic t_reset;
        chk("R9 reset done", 64'(done), 64'd0);
        chk("R9 reset busy", 64'(busy), 64'd0);
        chk("R1 reset valid", 64'(res_valid), 64'd0);
    endtask

    task automatic t_fixed;
        for (int i = 0; i < 88; i++) wreg(3'd0, i, ADDR_W'(i));
        wreg(3'd3, 0, ADDR_W'(36'hC06));
        lookup(36'h0_0000, 36'h0_1000, 8'd0,  1'b0, 1'b1, "R3 fix 0x00000");
        lookup(36'h7_0000, 36'h7_1000, 8'd7,  1'b0, 1'b1, "R3 fix 0x70000");
        lookup(36'h8_0000, 36'h8_1000, 8'd8,  1'b0, 1'b1, "R3 fix 0x80000");
        lookup(36'hB_C000, 36'hB_D000, 8'd23, 1'b0, 1'b1, "R3 fix 0xBC000");
        lookup(36'hC_0000, 36'hC_1000, 8'd24, 1'b0, 1'b1, "R3 fix 0xC0000");
        lookup(36'hC_5000, 36'hC_6000, 8'd29, 1'b0, 1'b1, "R3 fix 0xC5000");
        lookup(36'hF_F000, 36'h10_0000, 8'd87, 1'b0, 1'b1, "R2 fix last entry");
    endtask

    task automatic t_variable;
        lookup(36'h20_0000, 36'h30_0000, 8'd6, 1'b1, 1'b1, "R6 default only");
        set_var(0, 36'h100_0000, 20, 8'd4, 1'b0);
        lookup(36'h100_0000, 36'h101_0000, 8'd6, 1'b1, 1'b1, "R4 range off ignored");
        set_var(0, 36'h100_0000, 20, 8'd4, 1'b1);
        lookup(36'h100_0000, 36'h101_0000, 8'd4, 1'b1, 1'b1, "R4 range hit");
        lookup(36'h110_0000, 36'h111_0000, 8'd6, 1'b1, 1'b1, "R4 just outside");
    endtask

    task automatic t_overlap;
        set_var(1, 36'h100_0000, 24, 8'd6, 1'b1);
        lookup(36'h100_0000, 36'h100_1000, 8'd4, 1'b0, 1'b1, "R5 WT+WB");
        set_var(2, 36'h100_0000, 20, 8'd1, 1'b1);
        lookup(36'h100_0000, 36'h100_1000, 8'd0, 1'b0, 1'b1, "R5 WT+WC gives UC");
        set_var(2, 36'h100_0000, 20, 8'd0, 1'b1);
        lookup(36'h100_0000, 36'h100_1000, 8'd0, 1'b0, 1'b1, "R5 UC wins");
        set_var(2, 36'h0, 20, 8'd0, 1'b0);
        set_var(1, 36'h100_0000, 24, 8'd4, 1'b1);
        lookup(36'h100_0000, 36'h100_1000, 8'd4, 1'b0, 1'b1, "R6 two equal hits not uniform");
        set_var(1, 36'h0, 20, 8'd0, 1'b0);
    endtask

    task automatic t_span;
        lookup(36'hF0_0000, 36'h110_0000, 8'd4, 1'b0, 1'b1, "R7 cross range base");
        lookup(36'hF0_0000, 36'h120_0000, 8'd4, 1'b0, 1'b1, "R7 enclose range");
        set_var(3, 36'h300_0000, 20, 8'd0, 1'b1);
        lookup(36'h2F0_0000, 36'h310_0000, 8'd0, 1'b0, 1'b1, "R7 span into UC");
    endtask

    task automatic t_modes;
        wreg(3'd3, 0, ADDR_W'(36'h806));
        lookup(36'h0, 36'h1000, 8'd6, 1'b1, 1'b1, "R2 fixed disabled uses default");
        wreg(3'd3, 0, ADDR_W'(36'h800));
        lookup(36'h1_0000_0000, 36'h1_0010_0000, 8'd0, 1'b1, 1'b1, "R8 no limit");
        wreg(3'd4, 0, 36'h2_0000_0000);
        lookup(36'h1_0000_0000, 36'h1_0010_0000, 8'd6, 1'b1, 1'b1, "R8 forced WB");
        lookup(36'h1_FFF0_0000, 36'h2_0000_0000, 8'd0, 1'b1, 1'b1, "R8 end at limit");
        lookup(36'hF000_0000, 36'hF000_1000, 8'd0, 1'b1, 1'b1, "R8 below 4GiB");
        wreg(3'd3, 0, ADDR_W'(36'h006));
        lookup(36'h20_0000, 36'h21_0000, 8'hFF, 1'b0, 1'b0, "R1 global off");
        wreg(3'd3, 0, ADDR_W'(36'hC06));
    endtask

    task automatic t_busy;
        int dn;
        logic [7:0] ty;
        dn = 0; ty = 8'h55;
        @(negedge clk);
        req = 1'b1; req_start = 36'hF0_0000; req_end = 36'h120_0000;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        req = 1'b1; req_start = 36'h0; req_end = 36'h1000;   // arrives while busy
        for (int c = 0; c < 80; c++) begin
            @(negedge clk);
            req = 1'b0;
            if (done) begin
                dn++;
                ty = res_type;
                req = 1'b1; req_start = 36'h0; req_end = 36'h1000;  // same cycle as done
            end
        end
        req = 1'b0;
        chk("R9 single completion", 64'(dn), 64'd1);
        chk("R9 first request result", 64'(ty), 64'd4);
        chk("R9 result held", 64'(res_type), 64'd4);
        chk("R9 idle after", 64'(busy), 64'd0);
    endtask

    task automatic finish_run;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        lookup(36'h20_0000, 36'h20_1000, 8'hFF, 1'b0, 1'b0, "R1 never loaded");
        t_fixed();
        t_variable();
        t_overlap();
        t_span();
        t_modes();
        t_busy();
        finish_run();
    end

endmodule